// File: doc/BRIEF.md
# Guarded Register Write Sequencer

This block sits between a host write port and a slow register macro that cannot be written reliably with a single access. Each host write turns into three strobes on the macro side, in a fixed order. The first two are zero writes to the status address. The third carries the host's own address and data. The strobes are spaced by a programmable period. After the third strobe the block waits a fixed settle interval, given in nanoseconds and converted to clock cycles at elaboration, before it takes the next host command.

The host sees a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the block is busy, `cmd_ready` stays low and an offered command waits, so it is never lost.

A separate timing control word holds the strobe period in bits 9:0 and a read-delay value in bits 30:26. The read-delay value is held for a neighbouring read path and is not used inside this block. All other bits of the word read as zero.

The sequencer has seven named states:

- `S_IDLE`: ready. Goes to `S_DUMMY1` when a command is taken.
- `S_DUMMY1`: first zero strobe. Goes to `S_GAP1` if the period is above 1, otherwise straight to `S_DUMMY2`.
- `S_GAP1`: waits out the period. Goes to `S_DUMMY2` when the gap counter reaches zero.
- `S_DUMMY2`: second zero strobe. Goes to `S_GAP2` or straight to `S_REAL`, by the same period rule.
- `S_GAP2`: waits out the period. Goes to `S_REAL` when the gap counter reaches zero.
- `S_REAL`: host strobe. Starts the settle timer and goes to `S_SETTLE`.
- `S_SETTLE`: waits for the timer. Returns to `S_IDLE` when the timer expires.

Top module: `gws_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `mac_we` is 0 and `tctl_word` reads 0x7C0003FF (period field 0x3FF, read-delay field 0x1F).
- R2: A command is taken on a rising edge with `cmd_valid` and `cmd_ready` both high. In the very next cycle `mac_we` is high with `mac_addr` equal to the status address (0) and `mac_wdata` equal to 0.
- R3: Each command produces exactly three strobes. The first two carry the status address and zero data. The third carries the address and data captured when the command was taken.
- R4: With P the period field (bits 9:0), and P = 0 treated as 1, the three strobes start at cycles A, A+P and A+2P, where A is the first cycle after acceptance.
- R5: Every strobe lasts one cycle, and `mac_we` is never high while `cmd_ready` is high.
- R6: With S = ceil(CLK_HZ × SETTLE_NS / 1e9) (250 by default), `cmd_ready` rises again in cycle A+2P+S+1. No strobe appears within S cycles after the third strobe.
- R7: `cmd_ready` drops in the cycle after acceptance. A command held on the port while the block is busy is taken at the first cycle `cmd_ready` is high and is executed in full.
- R8: A pulse on `tctl_we` loads bits 9:0 and 30:26 of `tctl_wdata` into the control word and clears every other bit. It is visible on `tctl_word` in the next cycle, and strobes of later commands use the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a write |
| cmd_ready | output | 1 | Block can take a write this cycle |
| cmd_addr | input | ADDR_W | Host write address |
| cmd_data | input | DATA_W | Host write data |
| tctl_we | input | 1 | Load the timing control word |
| tctl_wdata | input | 32 | New timing control word |
| tctl_word | output | 32 | Current timing control word |
| mac_we | output | 1 | One-cycle write strobe to the macro |
| mac_addr | output | ADDR_W | Macro write address |
| mac_wdata | output | DATA_W | Macro write data |

## Verification
The sequence is run with four period settings: the reset maximum 1023, 4, 1 and 0. The value 4 shows that the gap counter loads the right count and that strobes stay single-cycle. The value 1 gives back-to-back strobes with no gap state. The value 0 shows that an empty period is clamped to one cycle rather than wrapping the counter to a huge gap. A second command held valid during a busy sequence shows that stalled commands are kept and that the settle wait is timed from the third strobe, not from acceptance. The control word is loaded with all ones and with a mixed pattern to separate field bits from bits that must read zero.

// File: rtl/gws_pkg.sv
package gws_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_DUMMY1 = 3'd1,
        S_GAP1   = 3'd2,
        S_DUMMY2 = 3'd3,
        S_GAP2   = 3'd4,
        S_REAL   = 3'd5,
        S_SETTLE = 3'd6
    } gws_state_e;

    // Settle cycles: ceiling of clock rate times interval, at least one cycle.
    function automatic int settle_cycles(input longint clk_hz, input longint settle_ns);
        longint raw;
        raw = (clk_hz * settle_ns + 64'sd999_999_999) / 64'sd1_000_000_000;
        if (raw < 1) raw = 1;
        return int'(raw);
    endfunction

endpackage

// File: rtl/gws_timing_reg.sv
module gws_timing_reg #(
    parameter int WORD_W  = 32,
    parameter int PER_W   = 10,
    parameter int PER_LSB = 0,
    parameter int DLY_W   = 5,
    parameter int DLY_LSB = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word,
    output logic [PER_W-1:0]  period
);
    localparam logic [WORD_W-1:0] PER_ONES = {PER_W{1'b1}};
    localparam logic [WORD_W-1:0] DLY_ONES = {DLY_W{1'b1}};
    localparam logic [WORD_W-1:0] FIELD_MASK = (PER_ONES << PER_LSB) | (DLY_ONES << DLY_LSB);
    // Both fields reset to their maximum, so the reset value equals the mask.
    localparam logic [WORD_W-1:0] RESET_WORD = FIELD_MASK;

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else if (we) begin
            word_q <= wdata & FIELD_MASK;
        end
    end

    assign word   = word_q;
    assign period = word_q[PER_LSB +: PER_W];

endmodule

// File: rtl/gws_settle_timer.sv
module gws_settle_timer #(
    parameter int SETTLE_CYC = 250,
    parameter int CNT_W      = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/gws_seq_fsm.sv
module gws_seq_fsm
    import gws_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int PER_W       = 10,
    parameter int STATUS_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [PER_W-1:0]  period,
    input  logic              settle_done,
    output logic              cmd_ready,
    output logic              settle_start,
    output logic              mac_we,
    output logic [ADDR_W-1:0] mac_addr,
    output logic [DATA_W-1:0] mac_wdata
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [PER_W-1:0]  TWO    = PER_W'(2);

    gws_state_e        st_q, st_nxt;
    logic [PER_W-1:0]  gap_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              long_gap;

    // Period 0 and 1 both give back-to-back strobes with no gap state.
    assign long_gap = (period > PER_W'(1));

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_IDLE:   if (cmd_valid) st_nxt = S_DUMMY1;
            S_DUMMY1: st_nxt = long_gap ? S_GAP1 : S_DUMMY2;
            S_GAP1:   if (gap_q == '0) st_nxt = S_DUMMY2;
            S_DUMMY2: st_nxt = long_gap ? S_GAP2 : S_REAL;
            S_GAP2:   if (gap_q == '0) st_nxt = S_REAL;
            S_REAL:   st_nxt = S_SETTLE;
            S_SETTLE: if (settle_done) st_nxt = S_IDLE;
            default:  st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            gap_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (st_q == S_IDLE && cmd_valid) begin
                addr_q <= cmd_addr;
                data_q <= cmd_data;
            end
            if (st_q == S_DUMMY1 || st_q == S_DUMMY2) begin
                gap_q <= period - TWO;
            end else if ((st_q == S_GAP1 || st_q == S_GAP2) && gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    always_comb begin
        cmd_ready    = 1'b0;
        settle_start = 1'b0;
        mac_we       = 1'b0;
        mac_addr     = '0;
        mac_wdata    = '0;
        unique case (st_q)
            S_IDLE: cmd_ready = 1'b1;
            S_DUMMY1, S_DUMMY2: begin
                mac_we   = 1'b1;
                mac_addr = STAT_A;
            end
            S_REAL: begin
                mac_we       = 1'b1;
                mac_addr     = addr_q;
                mac_wdata    = data_q;
                settle_start = 1'b1;
            end
            S_GAP1, S_GAP2, S_SETTLE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/gws_seq.sv
module gws_seq
    import gws_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CLK_HZ      = 50_000_000,
    parameter int SETTLE_NS   = 5000,
    parameter int STATUS_ADDR = 0,
    parameter int PER_W       = 10,
    parameter int PER_LSB     = 0,
    parameter int DLY_W       = 5,
    parameter int DLY_LSB     = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              tctl_we,
    input  logic [31:0]       tctl_wdata,
    output logic [31:0]       tctl_word,
    output logic              mac_we,
    output logic [ADDR_W-1:0] mac_addr,
    output logic [DATA_W-1:0] mac_wdata
);
    localparam int SETTLE_CYC = settle_cycles(longint'(CLK_HZ), longint'(SETTLE_NS));

    logic [PER_W-1:0] period;
    logic             settle_start;
    logic             settle_done;

    gws_timing_reg #(
        .WORD_W (32),
        .PER_W  (PER_W),
        .PER_LSB(PER_LSB),
        .DLY_W  (DLY_W),
        .DLY_LSB(DLY_LSB)
    ) u_treg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tctl_we),
        .wdata (tctl_wdata),
        .word  (tctl_word),
        .period(period)
    );

    gws_settle_timer #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (settle_start),
        .expired(settle_done)
    );

    gws_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PER_W      (PER_W),
        .STATUS_ADDR(STATUS_ADDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .period      (period),
        .settle_done (settle_done),
        .cmd_ready   (cmd_ready),
        .settle_start(settle_start),
        .mac_we      (mac_we),
        .mac_addr    (mac_addr),
        .mac_wdata   (mac_wdata)
    );

endmodule

// File: rtl/gws_seq_chk.sv
module gws_seq_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int PER_W       = 10,
    parameter int STATUS_ADDR = 0,
    parameter int SETTLE_CYC  = 250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic [PER_W-1:0]  period,
    input logic              mac_we,
    input logic [ADDR_W-1:0] mac_addr,
    input logic [DATA_W-1:0] mac_wdata
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(SETTLE_CYC);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    logic [1:0]        idx_q;
    logic [CNT_W-1:0]  since_q;
    logic              seen_q;
    logic [ADDR_W-1:0] cap_a_q;
    logic [DATA_W-1:0] cap_d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 2'd0;
            since_q <= '0;
            seen_q  <= 1'b0;
            cap_a_q <= '0;
            cap_d_q <= '0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                cap_a_q <= cmd_addr;
                cap_d_q <= cmd_data;
            end
            if (mac_we) idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
            if (mac_we && idx_q == 2'd2) begin
                seen_q  <= 1'b1;
                since_q <= CNT_W'(1);
            end else if (seen_q && since_q < SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R2: the first strobe follows acceptance at once and targets status with zero
    a_r2_first_status: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (mac_we && mac_addr == STAT_A && mac_wdata == '0));

    // R3: the first two strobes of each group are zero writes to status
    a_r3_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && idx_q != 2'd2) |-> (mac_addr == STAT_A && mac_wdata == '0));

    // R3: the third strobe carries what was captured at acceptance
    a_r3_real_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && idx_q == 2'd2) |-> (mac_addr == cap_a_q && mac_wdata == cap_d_q));

    // R5: single-cycle strobe when a gap exists
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && period > PER_W'(1)) |=> !mac_we);

    // R5: no strobe while idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mac_we);

    // R6: settle window after the real write is respected
    a_r6_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_we && seen_q && idx_q == 2'd0) |-> (since_q >= SAT));

    // R7: busy immediately after acceptance
    a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

endmodule

bind gws_seq gws_seq_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PER_W      (PER_W),
    .STATUS_ADDR(STATUS_ADDR),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .period   (tctl_word[PER_LSB +: PER_W]),
    .mac_we   (mac_we),
    .mac_addr (mac_addr),
    .mac_wdata(mac_wdata)
);

// File: tb/sim_gws_seq.sv
`timescale 1ns/1ps
module sim_gws_seq;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int S  = 250;   // ceil(50 MHz * 5000 ns)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          tctl_we = 1'b0;
    logic [31:0]   tctl_wdata = '0;
    logic [31:0]   tctl_word;
    logic          mac_we;
    logic [AW-1:0] mac_addr;
    logic [DW-1:0] mac_wdata;

    always #10 clk = ~clk;  // 50 MHz

    gws_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .tctl_we(tctl_we), .tctl_wdata(tctl_wdata), .tctl_word(tctl_word),
        .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          nlog = 0;
    int          log_cyc [64];
    logic [AW-1:0] log_a [64];
    logic [DW-1:0] log_d [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && mac_we && nlog < 64) begin
            log_cyc[nlog] <= cyc;
            log_a[nlog]   <= mac_addr;
            log_d[nlog]   <= mac_wdata;
            nlog          <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Issue one command; returns acceptance cycle A and cycle ready is seen again.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            output int acc, output int rdy, output int base);
        @(negedge clk);
        base = nlog;
        cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        rdy = cyc;
        @(negedge clk);
    endtask

    task automatic check_group(input int base, input int acc, input int p,
                               input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input string tag);
        int pe;
        pe = (p == 0) ? 1 : p;
        for (int k = 0; k < 3; k++) begin
            chk(log_cyc[base+k] == acc + k*pe, tag, $sformatf("strobe %0d cycle", k),
                log_cyc[base+k], acc + k*pe);
            chk(log_a[base+k] == ((k == 2) ? a : '0), "R3", $sformatf("strobe %0d addr", k),
                log_a[base+k], (k == 2) ? a : 0);
            chk(log_d[base+k] == ((k == 2) ? d : '0), "R3", $sformatf("strobe %0d data", k),
                log_d[base+k], (k == 2) ? d : 0);
        end
    endtask

    task automatic set_ctrl(input logic [31:0] w);
        @(negedge clk);
        tctl_we = 1'b1; tctl_wdata = w;
        @(negedge clk);
        tctl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
        chk(mac_we == 1'b0, "R1", "strobe after reset", mac_we, 0);
        chk(tctl_word == 32'h7C00_03FF, "R1", "control word reset", tctl_word, 32'h7C00_03FF);
    endtask

    task automatic t_default_period();
        int acc, rdy, base;
        do_write(8'h1C, 32'hDEAD_BEEF, acc, rdy, base);
        chk(nlog - base == 3, "R3", "strobe count P=1023", nlog - base, 3);
        check_group(base, acc, 1023, 8'h1C, 32'hDEAD_BEEF, "R4");
        chk(rdy == acc + 2*1023 + S + 1, "R6", "ready return P=1023", rdy, acc + 2*1023 + S + 1);
    endtask

    task automatic t_ctrl_reg();
        set_ctrl(32'hFFFF_FFFF);
        chk(tctl_word == 32'h7C00_03FF, "R8", "all ones masked", tctl_word, 32'h7C00_03FF);
        set_ctrl(32'h1234_5678);
        chk(tctl_word == 32'h1000_0278, "R8", "mixed pattern", tctl_word, 32'h1000_0278);
    endtask

    task automatic t_period(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int acc, rdy, base;
        set_ctrl(32'(p));
        chk(tctl_word == 32'(p), "R8", "period load", tctl_word, p);
        do_write(a, d, acc, rdy, base);
        chk(nlog - base == 3, "R5", $sformatf("single-cycle strobes P=%0d", p), nlog - base, 3);
        check_group(base, acc, p, a, d, "R4");
        chk(rdy == acc + 2*((p == 0) ? 1 : p) + S + 1, "R6", $sformatf("ready return P=%0d", p),
            rdy, acc + 2*((p == 0) ? 1 : p) + S + 1);
    endtask

    task automatic t_stall();
        int a1, a2, rdy, base;
        set_ctrl(32'd4);
        @(negedge clk);
        base = nlog;
        cmd_valid = 1'b1; cmd_addr = 8'h21; cmd_data = 32'h1111_2222;
        while (!cmd_ready) @(negedge clk);
        a1 = cyc + 1;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R7", "busy after take", cmd_ready, 0);
        cmd_addr = 8'h42; cmd_data = 32'h3333_4444;
        while (!cmd_ready) @(negedge clk);
        a2 = cyc + 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        rdy = cyc;
        @(negedge clk);
        chk(a2 == a1 + 8 + S + 2, "R7", "held command taken", a2, a1 + 8 + S + 2);
        chk(nlog - base == 6, "R7", "both commands executed", nlog - base, 6);
        check_group(base, a1, 4, 8'h21, 32'h1111_2222, "R7");
        check_group(base + 3, a2, 4, 8'h42, 32'h3333_4444, "R7");
        chk(log_cyc[base+3] - log_cyc[base+2] >= S, "R6", "settle gap", 
            log_cyc[base+3] - log_cyc[base+2], S);
        chk(rdy == a2 + 8 + S + 1, "R6", "ready after second", rdy, a2 + 8 + S + 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_period();
        t_ctrl_reg();
        t_period(4, 8'h05, 32'hA5A5_0001);
        t_period(1, 8'h7F, 32'h0000_00FF);
        t_period(0, 8'h80, 32'hCAFE_F00D);
        t_stall();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule